// File: doc/BRIEF.md
# Request/Acknowledge Job Controller with Watchdog Timeout

This block pairs a requesting controller with a worker controller on one clock. The two talk over an internal four-phase handshake: a `start` line that the requester drives and a `done` line that the worker drives. When the requester accepts a job request, it raises `start` and waits for the worker to drop `done`, which means the worker has taken the job. It then waits for `done` to come back high. The worker's job is a fixed placeholder of `WORK_CYCLES` clock cycles.

A reloadable down-counter guards the wait for completion. If `done` has not returned before the counter runs out, the requester gives up and pulses a timeout status instead of a result status. After either pulse the requester returns to idle. The `start` and `done` lines are brought out so that the handshake can be observed. The request input and the status pulses are plain control pins with no flow control.

Top module: `job_handshake`

## Requirements
- R1: Reset is active-low and asynchronous. While it is asserted the outputs read `hs_start_o`=0, `hs_done_o`=1, `result_o`=0 and `timeout_o`=0, with no clock edge needed.
- R2: Call the first clock edge that samples `req_i`=1 in idle edge 1. `hs_start_o` is high after edges 2, 3 and 4 and low at every other time.
- R3: The requester does not treat the job as taken until `done` has gone low. The wait phase, and with it the timeout count, starts at edge 4.
- R4: When the worker sees `start` in idle, it drops `done` on the next edge (edge 3). `done` stays low for `WORK_CYCLES`+1 cycles and rises at edge `WORK_CYCLES`+4.
- R5: After the work finishes, the worker holds `done` high. It does not return to idle while `start` is still high. With no new request, `done` stays high and `start` stays low.
- R6: A completed job gives a one-cycle `result_o` pulse after edge `WORK_CYCLES`+5, and no `timeout_o` pulse.
- R7: The counter is loaded with `TIMEOUT` (default 50) at edge 4 and counts down by one per cycle. If `done` has not risen when it reaches 0, a one-cycle `timeout_o` pulse follows edge `TIMEOUT`+5, and no `result_o` pulse occurs for that request.
- R8: When `done` is seen high in the same cycle that the counter reads 0 (`WORK_CYCLES` = `TIMEOUT`), completion wins and `result_o` pulses.
- R9: `result_o` and `timeout_o` never pulse in the same cycle. Each pulse lasts exactly one cycle.
- R10: `req_i` is ignored while a request is in progress. It has no effect on the handshake or on the status pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Job request, sampled in idle |
| hs_start_o | output | 1 | Handshake start line (requester to worker) |
| hs_done_o | output | 1 | Handshake done line (worker to requester) |
| result_o | output | 1 | One-cycle pulse on completion |
| timeout_o | output | 1 | One-cycle pulse when the wait expires |

## Verification
The bench checks the exact edge at which `start` rises and falls and at which `done` falls and rises. A requester that skipped the wait for `done` to fall would finish early or re-trigger, and the check on the `start` window would catch it. Three configurations are run side by side: short work, work exactly equal to the timeout, and work one cycle longer than the timeout. An off-by-one in the counter load or in the priority of the expiry check moves the pulse or flips result into timeout. Extra request pulses are sent while a job is in flight, and reset is asserted in the middle of a job, to expose a requester that re-arms while busy or a reset that waits for a clock edge.

// File: rtl/jh_pkg.sv
package jh_pkg;
  typedef enum logic [2:0] {
    M_IDLE = 3'd0,
    M_REQ  = 3'd1,
    M_WAIT = 3'd2,
    M_HAVE = 3'd3,
    M_TOUT = 3'd4
  } mst_st_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WORK = 2'd1,
    S_FIN  = 2'd2
  } slv_st_e;
endpackage

// File: rtl/jh_master.sv
module jh_master
  import jh_pkg::*;
#(
  parameter int TIMEOUT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic done_i,
  output logic start_o,
  output logic result_o,
  output logic timeout_o
);
  localparam int DLY_W = $clog2(2 * TIMEOUT + 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(TIMEOUT);

  mst_st_e          st_q;
  logic             start_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= M_IDLE;
      start_q <= 1'b0;
      dly_q   <= '0;
    end else begin
      start_q <= 1'b0;
      if (dly_q != '0) dly_q <= dly_q - 1'b1;
      case (st_q)
        M_IDLE: if (req_i) st_q <= M_REQ;
        M_REQ: begin
          start_q <= 1'b1;
          if (!done_i) begin
            dly_q <= DLY_LOAD;
            st_q  <= M_WAIT;
          end
        end
        M_WAIT: begin
          if (done_i)             st_q <= M_HAVE;
          else if (dly_q == '0)   st_q <= M_TOUT;
        end
        M_HAVE:  st_q <= M_IDLE;
        M_TOUT:  st_q <= M_IDLE;
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign start_o   = start_q;
  assign result_o  = (st_q == M_HAVE);
  assign timeout_o = (st_q == M_TOUT);

  // R6
  result_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_o |-> $past(done_i));
  // R7
  timeout_done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !$past(done_i));
  // R7
  dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q <= DLY_LOAD);
  // R9
  result_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_o |=> (!result_o && !timeout_o));
  // R9
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> (!timeout_o && !result_o));
endmodule

// File: rtl/jh_slave.sv
module jh_slave
  import jh_pkg::*;
#(
  parameter int WORK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = (WORK_CYCLES > 1) ? $clog2(WORK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORK_CYCLES - 1);

  slv_st_e          st_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      done_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          done_q <= 1'b1;
          if (start_i) begin
            done_q <= 1'b0;
            cnt_q  <= '0;
            st_q   <= S_WORK;
          end
        end
        S_WORK: begin
          if (cnt_q == LAST) st_q  <= S_FIN;
          else               cnt_q <= cnt_q + 1'b1;
        end
        S_FIN: begin
          done_q <= 1'b1;
          if (!start_i) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done_o = done_q;

  // R4
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_o) |-> $past(start_i));
  // R5
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FIN && start_i) |=> (st_q == S_FIN && done_o));
endmodule

// File: rtl/job_handshake.sv
module job_handshake #(
  parameter int TIMEOUT     = 50,
  parameter int WORK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic hs_start_o,
  output logic hs_done_o,
  output logic result_o,
  output logic timeout_o
);
  logic start_w;
  logic done_w;

  jh_master #(.TIMEOUT(TIMEOUT)) u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .done_i    (done_w),
    .start_o   (start_w),
    .result_o  (result_o),
    .timeout_o (timeout_o)
  );

  jh_slave #(.WORK_CYCLES(WORK_CYCLES)) u_slave (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_w),
    .done_o  (done_w)
  );

  assign hs_start_o = start_w;
  assign hs_done_o  = done_w;

  // R2
  start_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_start_o) |-> $past(hs_done_o));
endmodule

// File: tb/test_job_handshake.sv
module test_job_handshake;
  localparam int TO   = 50;
  localparam int W_A  = 4;
  localparam int W_B  = 50;
  localparam int W_C  = 51;
  localparam int WIN  = 70;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic st_a, dn_a, rs_a, to_a;
  logic st_b, dn_b, rs_b, to_b;
  logic st_c, dn_c, rs_c, to_c;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  job_handshake #(.TIMEOUT(TO), .WORK_CYCLES(W_A)) i_job_handshake (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .hs_start_o(st_a), .hs_done_o(dn_a), .result_o(rs_a), .timeout_o(to_a));
  job_handshake #(.TIMEOUT(TO), .WORK_CYCLES(W_B)) i_job_handshake_edge (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .hs_start_o(st_b), .hs_done_o(dn_b), .result_o(rs_b), .timeout_o(to_b));
  job_handshake #(.TIMEOUT(TO), .WORK_CYCLES(W_C)) i_job_handshake_slow (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .hs_start_o(st_c), .hs_done_o(dn_c), .result_o(rs_c), .timeout_o(to_c));

  function automatic int exp_res(int w);
    return (w <= TO) ? w + 5 : -1;
  endfunction
  function automatic int exp_tout(int w);
    return (w > TO) ? TO + 5 : -1;
  endfunction

  task automatic check(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic idle_check(string rq);
    check(st_a == 1'b0 && st_b == 1'b0 && st_c == 1'b0, rq,
          {st_a, st_b, st_c}, 0);
    check(dn_a && dn_b && dn_c, rq, {dn_a, dn_b, dn_c}, 7);
    check(!(rs_a | rs_b | rs_c | to_a | to_b | to_c), rq,
          {rs_a, rs_b, rs_c, to_a, to_b, to_c}, 0);
  endtask

  // one request; hold = cycles req stays high; mid = edge of an extra pulse (0 = none)
  task automatic do_txn(int hold, int mid);
    int st_bad = 0, dn_bad = 0, both = 0;
    int ra_first = -1, ra_cnt = 0, ta_cnt = 0;
    int rb_first = -1, rb_cnt = 0, tb_cnt = 0;
    int tc_first = -1, tc_cnt = 0, rc_cnt = 0;
    @(negedge clk);
    req = 1'b1;
    for (int j = 1; j <= WIN; j++) begin
      @(negedge clk);
      if (j == hold) req = 1'b0;
      if (mid != 0 && j == mid - 1) req = 1'b1;
      if (mid != 0 && j == mid) req = 1'b0;
      if (j <= 12) begin
        if (st_a != (j >= 2 && j <= 4)) st_bad++;
        if (dn_a != !(j >= 3 && j <= 3 + W_A)) dn_bad++;
      end
      if ((rs_a && to_a) || (rs_b && to_b) || (rs_c && to_c)) both++;
      if (rs_a) begin ra_cnt++; if (ra_first < 0) ra_first = j; end
      if (to_a) ta_cnt++;
      if (rs_b) begin rb_cnt++; if (rb_first < 0) rb_first = j; end
      if (to_b) tb_cnt++;
      if (to_c) begin tc_cnt++; if (tc_first < 0) tc_first = j; end
      if (rs_c) rc_cnt++;
    end
    check(st_bad == 0, "R2 start window", st_bad, 0);
    check(dn_bad == 0, "R4 done low window", dn_bad, 0);
    check(ra_first == exp_res(W_A), "R6 result edge", ra_first, exp_res(W_A));
    check(ta_cnt == 0, "R6 no timeout", ta_cnt, 0);
    check(ra_cnt == ((mid > 0 && mid < ra_first) ? 1 : (mid > 0 ? 2 : 1)),
          "R10 result count", ra_cnt, (mid > 0 && mid > ra_first) ? 2 : 1);
    check(rb_first == exp_res(W_B) && rb_cnt == 1, "R8 expiry tie", rb_first, exp_res(W_B));
    check(tb_cnt == 0, "R8 no timeout on tie", tb_cnt, 0);
    check(tc_first == exp_tout(W_C) && tc_cnt == 1, "R7 timeout edge", tc_first, exp_tout(W_C));
    check(rc_cnt == 0, "R7 no result", rc_cnt, 0);
    check(both == 0, "R9 exclusive", both, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    idle_check("R1 reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    idle_check("R5 quiet idle");
    // directed cases
    do_txn(1, 0);
    do_txn(3, 0);
    do_txn(1, 20);
    repeat (8) @(negedge clk);
    idle_check("R5 idle after work");
    // mid-job reset
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b0;
    #1 idle_check("R1 async reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_check("R3 no spurious start");
    // random
    for (int k = 0; k < 20; k++) begin
      int h, m;
      h = 1 + int'($urandom_range(2, 0));
      m = ($urandom_range(1, 0) == 1) ? 14 + int'($urandom_range(30, 0)) : 0;
      do_txn(h, m);
      repeat (1 + int'($urandom_range(10, 0))) @(negedge clk);
      idle_check("R5 idle between");
    end
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule